// File: doc/BRIEF.md
# Banked External Memory Interface

This block lets an on-chip requester reach external asynchronous SRAM, ROM or flash without any glue logic. The requester presents a word-aligned byte address, a write flag, four byte strobes and a 32-bit write word. The two address bits above the 20-bit external range pick one of four banks. Each bank drives its own chip select and has its own setting for device width (8 or 16 bits) and for the number of wait cycles.

A 32-bit request is carried out as a series of narrow external cycles. An 8-bit bank needs four cycles and a 16-bit bank needs two, both in little-endian order. Byte lanes that are not selected are skipped on writes. Reads always fetch the whole word. Every external cycle holds its strobe low for one cycle plus the wait count of the bank, then spends one hold cycle with the strobe high. The internal ready pulse comes only after the last cycle. Bank settings are loaded through a small write port and are captured when a request is accepted.

Top module: `bank_xmem_if`

## Requirements
- R1: The bank is req_addr[21:20]. The chip select of that bank alone (xm_cs_n bit equal to the bank number, active low) is low from the first strobe of an access through its last hold cycle. All chip selects are high while no access is running.
- R2: Requests are word aligned (req_addr[1:0] = 0). On an 8-bit bank, byte lane i goes to external address {req_addr[19:2], i}. On a 16-bit bank, half-word h goes to {req_addr[19:2], h, 0}.
- R3: Each bank has a setting made of a width flag (1 = 16-bit) and a 4-bit wait count. The setting is written when cfg_we is high, using cfg_bank, cfg_wide and cfg_waits. After reset every bank is 8-bit with 15 waits. A request uses the setting of its bank as it stands when the request is accepted.
- R4: In every external cycle the strobe is low for exactly wait+1 clock cycles and is then high for one hold cycle. Reads use xm_oe_n and writes use xm_we_n. The two strobes are never low together.
- R5: A read runs four external cycles on an 8-bit bank (lanes 0,1,2,3) or two on a 16-bit bank (half-words 0,1). req_ready is high on the clock edge that is beats*(wait+2) edges after the accepting edge, and req_rdata then holds the assembled word, with lane 0 in bits 7:0.
- R6: A write runs one external cycle per selected byte on an 8-bit bank, and one per half-word with any selected byte on a 16-bit bank, in ascending order. xm_bls_n[k] is low only for selected bytes. A write with no strobe set runs no external cycle and signals ready on the accepting edge.
- R7: xm_doe is high only while xm_we_n is low or in the cycle right after it. It is never high while xm_oe_n is low, and it is low between accesses.
- R8: An 8-bit bank uses only data lane 7:0 (write data in xm_dout[7:0], read data from xm_din[7:0]) with xm_bls_n = 2'b10. A 16-bit read drives xm_bls_n = 2'b00.
- R9: xm_addr and xm_dout stay stable while a strobe is low.
- R10: req_ready is a single-cycle pulse. While it is high no strobe and no chip select is active. The next request is taken once the pulse has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one bank setting |
| cfg_bank | input | 2 | Bank whose setting is written |
| cfg_wide | input | 1 | 1 = 16-bit device, 0 = 8-bit device |
| cfg_waits | input | 4 | Extra strobe cycles per external cycle |
| req_valid | input | 1 | Request present, held until req_ready |
| req_addr | input | 22 | Byte address: bank in 21:20, word in 19:2 |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 4 | Byte strobes for writes |
| req_wdata | input | 32 | Write word |
| req_ready | output | 1 | One-cycle completion pulse |
| req_rdata | output | 32 | Read word, valid with req_ready |
| xm_cs_n | output | 4 | Per-bank chip selects, active low |
| xm_oe_n | output | 1 | Output enable (read strobe), active low |
| xm_we_n | output | 1 | Write enable (write strobe), active low |
| xm_bls_n | output | 2 | Byte lane selects, active low |
| xm_addr | output | 20 | External byte address |
| xm_dout | output | 16 | Data toward the pad |
| xm_doe | output | 1 | Pad driver enable for xm_dout |
| xm_din | input | 16 | Data from the pad |

## Verification
The embedded properties check, on every cycle, the pin relations that must always hold. At most one chip select may be active. A strobe must not appear without a chip select, and the two strobes must not overlap. The data driver must stay inside the write strobe plus its hold cycle and must never drive during a read. Address and write data must stay steady under a strobe, and ready must be a quiet one-cycle pulse. What only the directed scenarios can show involves expected values: the latency for each width and wait setting, the order and addresses of the beats, which bytes are skipped for each strobe pattern, the read data that is assembled, and the reset setting of each bank.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

  // Sequencer phases of one request
  typedef enum logic [1:0] {
    XS_IDLE = 2'd0,
    XS_STRB = 2'd1,
    XS_HOLD = 2'd2,
    XS_DONE = 2'd3
  } xm_state_e;

  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = 8 * WORD_BYTES;
  localparam int XDATA_W    = 16;
  localparam int LANE_IDX_W = $clog2(WORD_BYTES);

endpackage

// File: rtl/xmem_cfg_regs.sv
module xmem_cfg_regs #(
  parameter  int NBANK  = 4,
  parameter  int WAIT_W = 4,
  localparam int BSEL_W = $clog2(NBANK)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [BSEL_W-1:0]       wr_bank,
  input  logic                    wr_wide,
  input  logic [WAIT_W-1:0]       wr_waits,
  output logic [NBANK-1:0]        bank_wide,
  output logic [NBANK*WAIT_W-1:0] bank_waits
);

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    logic              wide_q, wide_d;
    logic [WAIT_W-1:0] waits_q, waits_d;
    logic              hit;

    assign hit = wr_en && (wr_bank == BSEL_W'(g));

    always_comb begin
      wide_d  = wide_q;
      waits_d = waits_q;
      if (hit) begin
        wide_d  = wr_wide;
        waits_d = wr_waits;
      end
    end

    // Reset setting: narrow device, slowest timing
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wide_q  <= 1'b0;
        waits_q <= '1;
      end else if (hit) begin
        wide_q  <= wide_d;
        waits_q <= waits_d;
      end
    end

    assign bank_wide[g]                  = wide_q;
    assign bank_waits[g*WAIT_W +: WAIT_W] = waits_q;
  end

endmodule

// File: rtl/xmem_beat_mask.sv
module xmem_beat_mask (
  input  logic       wide,
  input  logic       we,
  input  logic [3:0] be,
  output logic [3:0] mask
);

  // One bit per external cycle the request needs
  always_comb begin
    if (!we) begin
      mask = wide ? 4'b0011 : 4'b1111;
    end else if (wide) begin
      mask = {2'b00, |be[3:2], |be[1:0]};
    end else begin
      mask = be;
    end
  end

endmodule

// File: rtl/xmem_lane_pick.sv
module xmem_lane_pick #(
  parameter  int N  = 4,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx
);

  // Lowest pending lane first
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end

  assign any = |pend;

endmodule

// File: rtl/xmem_lane_drive.sv
module xmem_lane_drive #(
  parameter int ADDR_W = 20
) (
  input  logic              wide,
  input  logic              we,
  input  logic [ADDR_W-3:0] waddr,
  input  logic [1:0]        lane,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [ADDR_W-1:0] addr,
  output logic [15:0]       dout,
  output logic [1:0]        bls_n
);

  always_comb begin
    if (wide) begin
      addr  = {waddr, lane[0], 1'b0};
      dout  = lane[0] ? wdata[31:16] : wdata[15:0];
      bls_n = we ? ~(lane[0] ? be[3:2] : be[1:0]) : 2'b00;
    end else begin
      addr  = {waddr, lane};
      dout  = {8'h00, wdata[{lane, 3'b000} +: 8]};
      bls_n = 2'b10;
    end
  end

endmodule

// File: rtl/bank_xmem_if.sv
module bank_xmem_if
  import xmem_pkg::*;
#(
  parameter  int NBANK  = 4,
  parameter  int ADDR_W = 20,
  parameter  int WAIT_W = 4,
  localparam int BSEL_W = $clog2(NBANK),
  localparam int RA_W   = ADDR_W + BSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [BSEL_W-1:0]  cfg_bank,
  input  logic               cfg_wide,
  input  logic [WAIT_W-1:0]  cfg_waits,
  input  logic               req_valid,
  input  logic [RA_W-1:0]    req_addr,
  input  logic               req_we,
  input  logic [3:0]         req_be,
  input  logic [31:0]        req_wdata,
  output logic               req_ready,
  output logic [31:0]        req_rdata,
  output logic [NBANK-1:0]   xm_cs_n,
  output logic               xm_oe_n,
  output logic               xm_we_n,
  output logic [1:0]         xm_bls_n,
  output logic [ADDR_W-1:0]  xm_addr,
  output logic [15:0]        xm_dout,
  output logic               xm_doe,
  input  logic [15:0]        xm_din
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  // Bank settings
  logic [NBANK-1:0]        bank_wide;
  logic [NBANK*WAIT_W-1:0] bank_waits;

  xmem_cfg_regs #(.NBANK(NBANK), .WAIT_W(WAIT_W)) cfg_i (
    .clk       (clk),
    .rst_n     (arst_n),
    .wr_en     (cfg_we),
    .wr_bank   (cfg_bank),
    .wr_wide   (cfg_wide),
    .wr_waits  (cfg_waits),
    .bank_wide (bank_wide),
    .bank_waits(bank_waits)
  );

  // Request state
  xm_state_e         st_q, st_d;
  logic [BSEL_W-1:0] bank_q, bank_d;
  logic [ADDR_W-3:0] waddr_q, waddr_d;
  logic              we_q, we_d;
  logic [3:0]        be_q, be_d;
  logic [31:0]       wdata_q, wdata_d;
  logic              wide_q, wide_d;
  logic [WAIT_W-1:0] waits_q, waits_d;
  logic [WAIT_W-1:0] wcnt_q, wcnt_d;
  logic [3:0]        pend_q, pend_d;
  logic [1:0]        cur_q, cur_d;
  logic [31:0]       rdata_q, rdata_d;

  // Beats needed by the incoming request
  logic [BSEL_W-1:0] new_bank;
  logic              new_wide;
  logic [WAIT_W-1:0] new_waits;
  logic [3:0]        new_mask;
  logic              new_any;
  logic [1:0]        new_first;
  logic              pend_any;
  logic [1:0]        pend_first;

  assign new_bank  = req_addr[ADDR_W +: BSEL_W];
  assign new_wide  = bank_wide[new_bank];
  assign new_waits = bank_waits[new_bank*WAIT_W +: WAIT_W];

  xmem_beat_mask mask_i (
    .wide(new_wide),
    .we  (req_we),
    .be  (req_be),
    .mask(new_mask)
  );

  xmem_lane_pick #(.N(4)) pick_new_i (
    .pend(new_mask),
    .any (new_any),
    .idx (new_first)
  );

  xmem_lane_pick #(.N(4)) pick_pend_i (
    .pend(pend_q),
    .any (pend_any),
    .idx (pend_first)
  );

  // Next-state logic
  always_comb begin
    st_d    = st_q;
    bank_d  = bank_q;
    waddr_d = waddr_q;
    we_d    = we_q;
    be_d    = be_q;
    wdata_d = wdata_q;
    wide_d  = wide_q;
    waits_d = waits_q;
    wcnt_d  = wcnt_q;
    pend_d  = pend_q;
    cur_d   = cur_q;
    rdata_d = rdata_q;
    case (st_q)
      XS_IDLE: begin
        if (req_valid) begin
          bank_d  = new_bank;
          waddr_d = req_addr[ADDR_W-1:2];
          we_d    = req_we;
          be_d    = req_be;
          wdata_d = req_wdata;
          wide_d  = new_wide;
          waits_d = new_waits;
          if (!new_any) begin
            st_d = XS_DONE;
          end else begin
            cur_d  = new_first;
            pend_d = new_mask & ~(4'b0001 << new_first);
            wcnt_d = new_waits;
            st_d   = XS_STRB;
          end
        end
      end
      XS_STRB: begin
        if (wcnt_q == '0) begin
          st_d = XS_HOLD;
          if (!we_q) begin
            if (wide_q) rdata_d[{cur_q[0], 4'b0000} +: 16] = xm_din;
            else        rdata_d[{cur_q, 3'b000} +: 8]      = xm_din[7:0];
          end
        end else begin
          wcnt_d = wcnt_q - 1'b1;
        end
      end
      XS_HOLD: begin
        if (!pend_any) begin
          st_d = XS_DONE;
        end else begin
          cur_d  = pend_first;
          pend_d = pend_q & ~(4'b0001 << pend_first);
          wcnt_d = waits_q;
          st_d   = XS_STRB;
        end
      end
      default: begin
        st_d = XS_IDLE;
      end
    endcase
  end

  // Registers: control always, request fields only when taken
  logic take;
  assign take = (st_q == XS_IDLE) && req_valid;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= XS_IDLE;
      wcnt_q <= '0;
      pend_q <= '0;
      cur_q  <= '0;
    end else begin
      st_q   <= st_d;
      wcnt_q <= wcnt_d;
      pend_q <= pend_d;
      cur_q  <= cur_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      bank_q  <= '0;
      waddr_q <= '0;
      we_q    <= 1'b0;
      be_q    <= '0;
      wdata_q <= '0;
      wide_q  <= 1'b0;
      waits_q <= '0;
    end else if (take) begin
      bank_q  <= bank_d;
      waddr_q <= waddr_d;
      we_q    <= we_d;
      be_q    <= be_d;
      wdata_q <= wdata_d;
      wide_q  <= wide_d;
      waits_q <= waits_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)              rdata_q <= '0;
    else if (st_q == XS_STRB) rdata_q <= rdata_d;
  end

  // Pin decode
  logic active;
  assign active = (st_q == XS_STRB) || (st_q == XS_HOLD);

  for (genvar g = 0; g < NBANK; g++) begin : g_cs
    assign xm_cs_n[g] = !(active && (bank_q == BSEL_W'(g)));
  end

  assign xm_oe_n   = !((st_q == XS_STRB) && !we_q);
  assign xm_we_n   = !((st_q == XS_STRB) && we_q);
  assign xm_doe    = active && we_q;
  assign req_ready = (st_q == XS_DONE);
  assign req_rdata = rdata_q;

  xmem_lane_drive #(.ADDR_W(ADDR_W)) drive_i (
    .wide (wide_q),
    .we   (we_q),
    .waddr(waddr_q),
    .lane (cur_q),
    .be   (be_q),
    .wdata(wdata_q),
    .addr (xm_addr),
    .dout (xm_dout),
    .bls_n(xm_bls_n)
  );

  // Properties
  assert_cs_onehot_R1: assert property (@(posedge clk) disable iff (!arst_n)
    $onehot0(~xm_cs_n));

  assert_strobe_has_cs_R1: assert property (@(posedge clk) disable iff (!arst_n)
    (!xm_oe_n || !xm_we_n) |-> (xm_cs_n != '1));

  assert_aligned_req_R2: assert property (@(posedge clk) disable iff (!arst_n)
    req_valid |-> (req_addr[1:0] == 2'b00));

  assert_strobe_exclusive_R4: assert property (@(posedge clk) disable iff (!arst_n)
    !(!xm_oe_n && !xm_we_n));

  assert_drive_window_R7: assert property (@(posedge clk) disable iff (!arst_n)
    xm_doe |-> (!xm_we_n || $past(!xm_we_n)));

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!arst_n)
    xm_doe |-> xm_oe_n);

  assert_pins_stable_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (!xm_we_n && $past(!xm_we_n)) |-> ($stable(xm_addr) && $stable(xm_dout)));

  assert_read_addr_stable_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (!xm_oe_n && $past(!xm_oe_n)) |-> $stable(xm_addr));

  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!arst_n)
    req_ready |-> (xm_oe_n && xm_we_n && (xm_cs_n == '1)));

  assert_ready_pulse_R10: assert property (@(posedge clk) disable iff (!arst_n)
    req_ready |=> !req_ready);

endmodule

// File: tb/bank_xmem_if_tb.sv
`timescale 1ns/1ps
module bank_xmem_if_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [1:0]  cfg_bank;
  logic        cfg_wide;
  logic [3:0]  cfg_waits;
  logic        req_valid;
  logic [21:0] req_addr;
  logic        req_we;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        req_ready;
  logic [31:0] req_rdata;
  logic [3:0]  xm_cs_n;
  logic        xm_oe_n, xm_we_n, xm_doe;
  logic [1:0]  xm_bls_n;
  logic [19:0] xm_addr;
  logic [15:0] xm_dout, xm_din;

  always #2 clk = ~clk;

  bank_xmem_if dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_bank(cfg_bank), .cfg_wide(cfg_wide), .cfg_waits(cfg_waits),
    .req_valid(req_valid), .req_addr(req_addr), .req_we(req_we), .req_be(req_be),
    .req_wdata(req_wdata), .req_ready(req_ready), .req_rdata(req_rdata),
    .xm_cs_n(xm_cs_n), .xm_oe_n(xm_oe_n), .xm_we_n(xm_we_n), .xm_bls_n(xm_bls_n),
    .xm_addr(xm_addr), .xm_dout(xm_dout), .xm_doe(xm_doe), .xm_din(xm_din)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Memory model: 256 bytes per bank, width known to the bench
  logic [7:0]  mem [4][256];
  logic        tb_wide [4];
  int          strb_cycles = 0;
  int          beat_total = 0;
  int          viol = 0;
  logic [19:0] beat_addr [64];
  logic [1:0]  beat_bls [64];
  logic        prev_strb = 1'b0;
  logic        prev_we_low = 1'b0;

  function automatic logic [7:0] pat(int b, int a);
    return 8'((b * 61 + a * 7 + 17) & 255);
  endfunction

  function automatic logic [31:0] exp_word(int b, int w);
    int a = (w * 4) & 255;
    return {pat(b, a + 3), pat(b, a + 2), pat(b, a + 1), pat(b, a)};
  endfunction

  function automatic int cs_bank(logic [3:0] c);
    int r = -1;
    for (int i = 3; i >= 0; i--) if (!c[i]) r = i;
    return r;
  endfunction

  always_comb begin
    int b;
    int a;
    b = cs_bank(xm_cs_n);
    a = int'(xm_addr[7:0]);
    xm_din = 16'h0000;
    if (b >= 0 && !xm_oe_n) begin
      if (tb_wide[b]) xm_din = {mem[b][(a | 1)], mem[b][(a & 254)]};
      else            xm_din = {8'h00, mem[b][a]};
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int b = 0; b < 4; b++)
        for (int a = 0; a < 256; a++) mem[b][a] = pat(b, a);
      prev_strb = 1'b0;
      prev_we_low = 1'b0;
    end else begin
      logic strb;
      int   b;
      int   a;
      int   n;
      strb = !xm_oe_n || !xm_we_n;
      b = cs_bank(xm_cs_n);
      a = int'(xm_addr[7:0]);
      n = 0;
      for (int i = 0; i < 4; i++) if (!xm_cs_n[i]) n++;
      if (n > 1) viol++;
      if (xm_doe && !xm_oe_n) viol++;
      if (xm_doe && xm_we_n && !prev_we_low) viol++;
      if (strb) strb_cycles++;
      if (strb && !prev_strb) begin
        beat_addr[beat_total % 64] = xm_addr;
        beat_bls[beat_total % 64]  = xm_bls_n;
        beat_total++;
      end
      if (!xm_we_n && b >= 0 && xm_doe) begin
        if (tb_wide[b]) begin
          if (!xm_bls_n[0]) mem[b][(a & 254)] = xm_dout[7:0];
          if (!xm_bls_n[1]) mem[b][(a | 1)]   = xm_dout[15:8];
        end else begin
          mem[b][a] = xm_dout[7:0];
        end
      end
      prev_strb = strb;
      prev_we_low = !xm_we_n;
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int b, input logic wide, input logic [3:0] waits);
    cfg_we = 1'b1; cfg_bank = 2'(b); cfg_wide = wide; cfg_waits = waits;
    @(negedge clk);
    cfg_we = 1'b0;
    tb_wide[b] = wide;
  endtask

  // Runs one request; lat counts negedges up to the one that sees ready
  int          r_lat, r_beats, r_strb, r_base;
  logic [31:0] r_data;

  task automatic access(input int b, input logic [17:0] widx, input logic we,
                        input logic [3:0] be, input logic [31:0] wd);
    int s0;
    r_base = beat_total;
    s0 = strb_cycles;
    req_valid = 1'b1; req_addr = {2'(b), widx, 2'b00};
    req_we = we; req_be = be; req_wdata = wd;
    r_lat = 0;
    do begin
      @(negedge clk);
      r_lat++;
    end while (!req_ready && r_lat < 400);
    if (!req_ready) begin
      errors++;
      $display("FAIL R5 access timeout: actual %0d expected ready", r_lat);
    end
    r_data = req_rdata;
    r_beats = beat_total - r_base;
    r_strb = strb_cycles - s0;
    req_valid = 1'b0;
    @(negedge clk);
    chk("R10", "ready pulse width", 32'(req_ready), 32'd0);
  endtask

  task automatic t_reset_state();
    chk("R1", "cs idle", 32'(xm_cs_n), 32'hF);
    chk("R4", "strobes idle", {30'd0, xm_oe_n, xm_we_n}, 32'd3);
    chk("R7", "driver idle", 32'(xm_doe), 32'd0);
    chk("R10", "ready idle", 32'(req_ready), 32'd0);
  endtask

  task automatic t_reset_cfg_read();
    access(0, 18'd1, 1'b0, 4'hF, 32'd0);
    chk("R3", "reset latency", 32'(r_lat), 32'd69);
    chk("R4", "strobe cycles at 15 waits", 32'(r_strb), 32'd64);
    chk("R5", "read data bank0", r_data, exp_word(0, 1));
  endtask

  task automatic t_narrow_read();
    access(2, 18'h20005, 1'b0, 4'h0, 32'd0);
    chk("R5", "narrow read data", r_data, exp_word(2, 5));
    chk("R5", "narrow read latency", 32'(r_lat), 32'd21);
    chk("R5", "narrow read beats", 32'(r_beats), 32'd4);
    for (int k = 0; k < 4; k++)
      chk("R2", "narrow lane address", 32'(beat_addr[(r_base + k) % 64]),
          32'({18'h20005, 2'(k)}));
    chk("R8", "narrow read lane select", 32'(beat_bls[r_base % 64]), 32'd2);
  endtask

  task automatic t_wide_read();
    access(1, 18'd7, 1'b0, 4'hF, 32'd0);
    chk("R5", "wide read data", r_data, exp_word(1, 7));
    chk("R5", "wide read latency", 32'(r_lat), 32'd9);
    chk("R4", "wide read strobe cycles", 32'(r_strb), 32'd6);
    chk("R2", "wide half 0 address", 32'(beat_addr[r_base % 64]), 32'd28);
    chk("R2", "wide half 1 address", 32'(beat_addr[(r_base + 1) % 64]), 32'd30);
    chk("R8", "wide read lane select", 32'(beat_bls[r_base % 64]), 32'd0);
  endtask

  task automatic t_narrow_write();
    access(2, 18'd9, 1'b1, 4'b1010, 32'hA1B2C3D4);
    chk("R6", "narrow sparse write latency", 32'(r_lat), 32'd11);
    chk("R6", "narrow sparse beats", 32'(r_beats), 32'd2);
    chk("R6", "first lane address", 32'(beat_addr[r_base % 64]), 32'd37);
    chk("R6", "second lane address", 32'(beat_addr[(r_base + 1) % 64]), 32'd39);
    chk("R8", "narrow write lane select", 32'(beat_bls[r_base % 64]), 32'd2);
    chk("R6", "written bytes",
        {mem[2][39], mem[2][38], mem[2][37], mem[2][36]},
        {8'hA1, pat(2, 38), 8'hC3, pat(2, 36)});
  endtask

  task automatic t_wide_partial_write();
    access(1, 18'd3, 1'b1, 4'b0110, 32'h11223344);
    chk("R6", "wide partial latency", 32'(r_lat), 32'd9);
    chk("R6", "lane select half 0", 32'(beat_bls[r_base % 64]), 32'd1);
    chk("R6", "lane select half 1", 32'(beat_bls[(r_base + 1) % 64]), 32'd2);
    access(1, 18'd3, 1'b0, 4'h0, 32'd0);
    chk("R5", "wide read back", r_data, {pat(1, 15), 8'h22, 8'h33, pat(1, 12)});
  endtask

  task automatic t_wide_single();
    access(3, 18'd2, 1'b1, 4'b1100, 32'hDEADBEEF);
    chk("R6", "single half latency", 32'(r_lat), 32'd3);
    chk("R6", "single half beats", 32'(r_beats), 32'd1);
    chk("R2", "upper half address", 32'(beat_addr[r_base % 64]), 32'd10);
    chk("R6", "upper half bytes",
        {mem[3][11], mem[3][10], mem[3][9], mem[3][8]},
        {8'hDE, 8'hAD, pat(3, 9), pat(3, 8)});
  endtask

  task automatic t_empty_write();
    access(0, 18'd4, 1'b1, 4'b0000, 32'hFFFFFFFF);
    chk("R6", "empty write latency", 32'(r_lat), 32'd1);
    chk("R6", "empty write beats", 32'(r_beats), 32'd0);
    chk("R6", "empty write bytes",
        {mem[0][19], mem[0][18], mem[0][17], mem[0][16]}, exp_word(0, 4));
  endtask

  task automatic t_fast_narrow_read();
    access(0, 18'd2, 1'b0, 4'hF, 32'd0);
    chk("R3", "new setting latency", 32'(r_lat), 32'd9);
    chk("R5", "fast narrow data", r_data, exp_word(0, 2));
  endtask

  task automatic t_back_to_back();
    access(3, 18'd5, 1'b1, 4'hF, 32'h0BADF00D);
    access(2, 18'd6, 1'b0, 4'h0, 32'd0);
    chk("R5", "read after other-bank write", r_data, exp_word(2, 6));
    chk("R6", "full wide write bytes",
        {mem[3][23], mem[3][22], mem[3][21], mem[3][20]}, 32'h0BADF00D);
    chk("R7", "bus ownership violations", 32'(viol), 32'd0);
    chk("R1", "cs idle after traffic", 32'(xm_cs_n), 32'hF);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) tb_wide[i] = 1'b0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_bank = '0; cfg_wide = 1'b0; cfg_waits = '0;
    req_valid = 1'b0; req_addr = '0; req_we = 1'b0; req_be = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_reset_cfg_read();
    set_cfg(0, 1'b0, 4'd0);
    set_cfg(1, 1'b1, 4'd2);
    set_cfg(2, 1'b0, 4'd3);
    set_cfg(3, 1'b1, 4'd0);
    t_narrow_read();
    t_wide_read();
    t_narrow_write();
    t_wide_partial_write();
    t_wide_single();
    t_empty_write();
    t_fast_narrow_read();
    t_back_to_back();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(negedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule